// File: doc/BRIEF.md
# Interrupt Disable Threshold Controller

This block keeps a small software-programmed threshold that shuts out interrupt requests whose priority is at or below it. The threshold is separate from the CPU's own priority level, which this block reads but never changes. A request gets through only when its level is strictly above both the threshold and the CPU priority. A trap request always gets through.

The execute stage sends a one-cycle command that carries a new threshold. The value comes either from an immediate field or from the low bits of a 32-bit register operand. A flag on the command asks for the previous threshold to be returned, so that nested critical sections can save the old value and restore it later.

The command pins are plain control pins. A command is taken in any cycle in which `cmd_valid` is high, and there is no back-pressure. The read view shows the threshold, zero-extended, at all times and has no write path.

Top module: `irq_thr_ctrl`

## Requirements
- R1: After reset the threshold is 0 and `wb_valid` is low.
- R2: When `trap_req` is low, `irq_accept` is high exactly when `irq_level` is greater than the current threshold and greater than `cpu_ipl`. A level-0 request is never accepted.
- R3: `trap_req` high forces `irq_accept` high, whatever the threshold, `irq_level` and `cpu_ipl`.
- R4: A command in cycle t does not change the threshold seen in cycle t. The new value appears on `thr_view` and gates `irq_accept` from cycle t+1 onward.
- R5: The source of the new value is set by `cmd_src_reg`. When it is 1, `cmd_reg[2:0]` is used and `cmd_reg[31:3]` is ignored. When it is 0, `cmd_imm` is used.
- R6: A command with `cmd_ret` = 1 produces a one-cycle `wb_valid` pulse in cycle t+1. In that cycle `wb_data` holds the threshold from before the update, zero-extended to 32 bits. A command with `cmd_ret` = 0 produces no pulse.
- R7: `csr_rdata` always equals the current threshold in bits [2:0], with bits [31:3] at zero.
- R8: With a threshold of 0, acceptance is limited only by `cpu_ipl`.
- R9: Without a command, the threshold keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle threshold update command |
| cmd_src_reg | input | 1 | 1: take the value from `cmd_reg[2:0]`; 0: take it from `cmd_imm` |
| cmd_imm | input | 3 | Immediate threshold value |
| cmd_reg | input | 32 | Register operand; only the low 3 bits are used |
| cmd_ret | input | 1 | Return the previous threshold |
| irq_level | input | 3 | Priority of the pending interrupt (0 = none) |
| trap_req | input | 1 | Trap request, never masked |
| cpu_ipl | input | 3 | CPU priority level, read only |
| irq_accept | output | 1 | Request may be taken |
| thr_view | output | 3 | Current threshold |
| csr_rdata | output | 32 | Read-only register view of the threshold |
| wb_valid | output | 1 | Previous-threshold write-back strobe |
| wb_data | output | 32 | Previous threshold, zero-extended |

## Verification
The checker evaluates several rules on every cycle:
- trap pass-through;
- blocking at or below the threshold;
- acceptance above both levels;
- holding without a command;
- the one-cycle delay from a command to the new threshold;
- the timing and contents of the write-back pulse.

Only the bench scenarios show certain end-to-end behaviour:
- nested saves and restores;
- a threshold of 0 handing all gating back to `cpu_ipl`;
- the register source ignoring heavily populated upper bits;
- back-to-back commands each returning the value written by the one before.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic             upd;
    logic             ret;
    logic [LVL_W-1:0] lvl;
  } thr_cmd_t;
endpackage

// File: rtl/irqt_src_sel.sv
module irqt_src_sel #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              use_reg,
  input  logic [LVL_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_val,
  output logic [LVL_W-1:0]  sel_lvl
);
  // Upper operand bits carry no meaning for the threshold.
  logic unused_hi;
  assign unused_hi = ^reg_val[DATA_W-1:LVL_W];

  always_comb begin
    if (use_reg) sel_lvl = reg_val[LVL_W-1:0];
    else         sel_lvl = imm;
  end
endmodule

// File: rtl/irqt_level_reg.sv
module irqt_level_reg
  import irqt_pkg::*;
#(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  thr_cmd_t          cmd,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data
);
  localparam int unsigned PAD_W = DATA_W - LVL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= cmd.upd & cmd.ret;
      if (cmd.upd) begin
        lvl_q <= cmd.lvl;
        if (cmd.ret) wb_data <= {{PAD_W{1'b0}}, lvl_q};
      end
    end
  end
endmodule

// File: rtl/irqt_gate.sv
module irqt_gate #(
  parameter int unsigned LVL_W = 3
) (
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] cpu_ipl,
  input  logic [LVL_W-1:0] thr,
  input  logic             trap,
  output logic             accept
);
  logic above_thr, above_ipl;

  always_comb begin
    above_thr = irq_level > thr;
    above_ipl = irq_level > cpu_ipl;
    accept    = trap | (above_thr & above_ipl);
  end
endmodule

// File: rtl/irq_thr_ctrl.sv
module irq_thr_ctrl
  import irqt_pkg::*;
#(
  parameter int unsigned LVL_W  = irqt_pkg::LVL_W,
  parameter int unsigned DATA_W = irqt_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_src_reg,
  input  logic [LVL_W-1:0]  cmd_imm,
  input  logic [DATA_W-1:0] cmd_reg,
  input  logic              cmd_ret,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              trap_req,
  input  logic [LVL_W-1:0]  cpu_ipl,
  output logic              irq_accept,
  output logic [LVL_W-1:0]  thr_view,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data
);
  localparam int unsigned PAD_W = DATA_W - LVL_W;

  logic [LVL_W-1:0] new_lvl;
  logic [LVL_W-1:0] thr_q;
  thr_cmd_t         cmd;

  irqt_src_sel #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_sel (
    .use_reg (cmd_src_reg),
    .imm     (cmd_imm),
    .reg_val (cmd_reg),
    .sel_lvl (new_lvl)
  );

  always_comb begin
    cmd.upd = cmd_valid;
    cmd.ret = cmd_ret;
    cmd.lvl = new_lvl;
  end

  irqt_level_reg #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .lvl_q    (thr_q),
    .wb_valid (wb_valid),
    .wb_data  (wb_data)
  );

  irqt_gate #(.LVL_W(LVL_W)) u_gate (
    .irq_level (irq_level),
    .cpu_ipl   (cpu_ipl),
    .thr       (thr_q),
    .trap      (trap_req),
    .accept    (irq_accept)
  );

  assign thr_view  = thr_q;
  assign csr_rdata = {{PAD_W{1'b0}}, thr_q};
endmodule

// File: rtl/irqt_chk.sv
module irqt_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_src_reg,
  input logic [LVL_W-1:0]  cmd_imm,
  input logic [DATA_W-1:0] cmd_reg,
  input logic              cmd_ret,
  input logic [LVL_W-1:0]  irq_level,
  input logic              trap_req,
  input logic [LVL_W-1:0]  cpu_ipl,
  input logic              irq_accept,
  input logic [LVL_W-1:0]  thr_view,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data
);
  a_r3_trap_passes: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> irq_accept);

  a_r2_block_at_or_below: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && irq_level <= thr_view) |-> !irq_accept);

  a_r2_accept_above_both: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level > thr_view && irq_level > cpu_ipl) |-> irq_accept);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(thr_view));

  a_r4_imm_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_src_reg) |=> thr_view == $past(cmd_imm));

  a_r5_reg_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_src_reg) |=> thr_view == $past(cmd_reg[LVL_W-1:0]));

  a_r6_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ret) |=> (wb_valid && wb_data == DATA_W'($past(thr_view))));

  a_r6_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ret) |=> !wb_valid);

  a_r7_csr_view: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata == DATA_W'(thr_view));
endmodule

bind irq_thr_ctrl irqt_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src_reg(cmd_src_reg),
  .cmd_imm(cmd_imm), .cmd_reg(cmd_reg), .cmd_ret(cmd_ret), .irq_level(irq_level),
  .trap_req(trap_req), .cpu_ipl(cpu_ipl), .irq_accept(irq_accept),
  .thr_view(thr_view), .csr_rdata(csr_rdata), .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/irq_thr_ctrl_bench.sv
`timescale 1ns/1ps
module irq_thr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_src_reg = 1'b0, cmd_ret = 1'b0;
  logic [2:0]  cmd_imm = '0, irq_level = '0, cpu_ipl = '0;
  logic [31:0] cmd_reg = '0;
  logic        trap_req = 1'b0;
  logic        irq_accept, wb_valid;
  logic [2:0]  thr_view;
  logic [31:0] csr_rdata, wb_data;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  logic [2:0]  m_thr = '0;
  logic        m_wbv = 1'b0;
  logic [31:0] m_wbd = '0;

  always #4 clk = ~clk;

  irq_thr_ctrl u_irq_thr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src_reg(cmd_src_reg),
    .cmd_imm(cmd_imm), .cmd_reg(cmd_reg), .cmd_ret(cmd_ret), .irq_level(irq_level),
    .trap_req(trap_req), .cpu_ipl(cpu_ipl), .irq_accept(irq_accept),
    .thr_view(thr_view), .csr_rdata(csr_rdata), .wb_valid(wb_valid), .wb_data(wb_data)
  );

  function automatic logic exp_acc(logic tr, logic [2:0] lv, logic [2:0] th, logic [2:0] ip);
    return tr | ((lv > th) & (lv > ip));
  endfunction

  function automatic logic [2:0] exp_sel(logic sr, logic [2:0] im, logic [31:0] rv);
    return sr ? rv[2:0] : im;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive inputs at the falling edge, compare, then advance the model at the rising edge.
  task automatic step(logic v, logic sr, logic [2:0] im, logic [31:0] rv, logic rt,
                      logic [2:0] lv, logic tr, logic [2:0] ip, string tag);
    @(negedge clk);
    cmd_valid = v; cmd_src_reg = sr; cmd_imm = im; cmd_reg = rv; cmd_ret = rt;
    irq_level = lv; trap_req = tr; cpu_ipl = ip;
    #1;
    chk({tag, " R2/R3 accept"}, 32'(irq_accept), 32'(exp_acc(tr, lv, m_thr, ip)));
    chk("R4/R9 thr_view", 32'(thr_view), 32'(m_thr));
    chk("R7 csr_rdata", csr_rdata, {29'b0, m_thr});
    chk("R6 wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) chk("R6 wb_data", wb_data, m_wbd);
    @(posedge clk);
    m_wbv = v & rt;
    if (v) begin
      if (rt) m_wbd = {29'b0, m_thr};
      m_thr = exp_sel(sr, im, rv);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset thr", 32'(thr_view), 32'd0);
    chk("R1 reset wb_valid", 32'(wb_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: threshold 0 leaves only cpu_ipl gating; level 0 never taken.
    for (int l = 0; l < 8; l++) step(0, 0, 0, 0, 0, 3'(l), 0, 3'd0, "R8");
    for (int l = 0; l < 8; l++) step(0, 0, 0, 0, 0, 3'(l), 0, 3'd4, "R8");
    // R4: command cycle still uses the old threshold; R6 write-back of prior value.
    step(1, 0, 3'd7, 0, 1, 3'd7, 0, 3'd0, "R4");
    for (int l = 0; l < 8; l++) step(0, 0, 0, 0, 0, 3'(l), 0, 3'd0, "R2");
    // R3: trap passes even when everything is masked.
    step(0, 0, 0, 0, 0, 3'd0, 1, 3'd7, "R3");
    // R5: register source with noisy upper bits.
    step(1, 1, 3'd6, 32'hFFFF_FFFA, 1, 3'd3, 0, 3'd1, "R5");
    step(1, 1, 3'd7, 32'hA5A5_A5A0, 0, 3'd3, 0, 3'd1, "R5");
    // Nested save/restore and back-to-back updates.
    step(1, 0, 3'd3, 0, 1, 3'd4, 0, 3'd0, "R6");
    step(1, 0, 3'd5, 0, 1, 3'd4, 0, 3'd0, "R6");
    step(1, 0, 3'd3, 0, 1, 3'd4, 0, 3'd0, "R6");
    step(0, 0, 0, 0, 0, 3'd4, 0, 3'd0, "R9");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) == 0, 1'($urandom), 3'($urandom), $urandom, 1'($urandom),
           3'($urandom), ($urandom % 8) == 0, 3'($urandom), "rand");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "tail");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule